// File: doc/BRIEF.md
# Timer Capture Channel

This block is one capture channel that sits beside a shared free-running timer count. A four-way multiplexer chooses the channel's input: one of two external pins, a constant low or a constant high. The chosen signal passes through a register chain clocked by the timer clock. A control bit decides whether the edge detector takes the signal after one stage or after the full two-stage synchronizer. When the programmed edge arrives, the current count is copied into the capture register.

Each capture sets an interrupt flag. An interrupt request leaves the block only while the enable input is high. If a capture lands while the flag from the previous capture is still set, a sticky overflow flag records the lost value. Software clears each flag with its own write strobe. Software can also force a capture by moving the source select between the two constant sources. Two status outputs report the chosen input: its live level, and the conditioned level held at the last compare-equal event.

Top module: `capture_channel`

## Requirements
- R1: After reset, `capValue`, `capFlag`, `ovfFlag`, `irq` and `inLatched` are all 0. The input stages also reset to 0, so a source that is high when reset is released counts as a rising edge.
- R2: `srcSel` picks the input: 00 = `srcA`, 01 = `srcB`, 10 = constant 0, 11 = constant 1. `inLevel` shows the chosen raw level combinationally.
- R3: `edgeMode` 01 captures on rising edges of the conditioned input, 10 on falling edges, and 11 on both. A capture loads `capValue` with the value `count` had at the capturing clock edge.
- R4: With `syncEn` = 0, a change of the chosen input made before clock edge k is captured at edge k+1. With `syncEn` = 1 it is captured at edge k+2.
- R5: A capture sets `capFlag`. `irq` equals `capFlag` AND `irqEn`.
- R6: `clrFlag` clears `capFlag` at the next edge. If a capture happens in the same cycle, the capture wins and the flag stays 1.
- R7: `ovfFlag` is set when a capture happens while `capFlag` is 1, judged on the flag value before any clear in that cycle. It stays set until `clrOvf` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R8: On a clock edge with `equEvent` high, `inLatched` takes the conditioned input: the level the edge detector sees in that cycle.
- R9: Moving `srcSel` from 10 to 11 makes a rising edge, and from 11 to 10 a falling edge. Either one captures like a pin edge.
- R10: With `edgeMode` = 00, no capture happens. `capValue` and `capFlag` keep their values and `ovfFlag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| count | input | CNT_W | Shared timer count |
| srcA | input | 1 | External input A |
| srcB | input | 1 | External input B |
| srcSel | input | 2 | Input source select |
| syncEn | input | 1 | 1 = full synchronizer, 0 = single stage |
| edgeMode | input | 2 | Capture edge selection |
| equEvent | input | 1 | Compare-equal event, latches the input |
| irqEn | input | 1 | Interrupt enable |
| clrFlag | input | 1 | Write strobe clearing the interrupt flag |
| clrOvf | input | 1 | Write strobe clearing the overflow flag |
| capValue | output | CNT_W | Captured count |
| capFlag | output | 1 | Capture interrupt flag |
| ovfFlag | output | 1 | Sticky capture-overflow flag |
| irq | output | 1 | Interrupt request |
| inLevel | output | 1 | Live level of the chosen input |
| inLatched | output | 1 | Conditioned input held at the last compare-equal event |

## Verification
The assertions assume that all inputs are stable around the rising clock edge and that the reset is held low for at least one edge. They also assume the write strobes are single-cycle-wide requests that may coincide with captures at any time. The bench meets these assumptions by changing every input only at the falling edge. Its random stimulus toggles the pins, the select, the mode and the sync setting freely, so edges created by a select or sync switch are also checked against the model. Strobe densities are chosen so that clears collide with captures often.

// File: rtl/cap_chan_pkg.sv
package cap_chan_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeMode_e;

  typedef enum logic [1:0] {
    SRC_A    = 2'b00,
    SRC_B    = 2'b01,
    SRC_LOW  = 2'b10,
    SRC_HIGH = 2'b11
  } srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // copy the count this edge
    logic latchIn;  // compare-equal latch request
    logic condIn;   // conditioned input level this cycle
  } capStrobes_t;

endpackage

// File: rtl/cap_chan_ctrl.sv
module cap_chan_ctrl
  import cap_chan_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcA,
  input  logic        srcB,
  input  logic [1:0]  srcSel,
  input  logic        syncEn,
  input  logic [1:0]  edgeMode,
  input  logic        equEvent,
  output logic        inLevel,
  output capStrobes_t strb
);

  localparam int LAST = SYNC_DEPTH - 1;

  logic                  selIn;
  logic [SYNC_DEPTH-1:0] stageQ;
  logic                  condIn;
  logic                  prevIn;
  logic                  riseDet;
  logic                  fallDet;
  logic                  capHit;

  always_comb begin
    unique case (srcSel_e'(srcSel))
      SRC_A:    selIn = srcA;
      SRC_B:    selIn = srcB;
      SRC_LOW:  selIn = 1'b0;
      default:  selIn = 1'b1;
    endcase
  end

  assign inLevel = selIn;

  // stage 0 is the single-register path, the last stage the synchronized one
  generate
    for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[0] <= 1'b0;
          else       stageQ[0] <= selIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[i] <= 1'b0;
          else       stageQ[i] <= stageQ[i-1];
        end
      end
    end
  endgenerate

  assign condIn = syncEn ? stageQ[LAST] : stageQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= 1'b0;
    else       prevIn <= condIn;
  end

  assign riseDet = condIn & ~prevIn;
  assign fallDet = ~condIn & prevIn;

  always_comb begin
    unique case (edgeMode_e'(edgeMode))
      EDGE_RISE: capHit = riseDet;
      EDGE_FALL: capHit = fallDet;
      EDGE_BOTH: capHit = riseDet | fallDet;
      default:   capHit = 1'b0;
    endcase
  end

  assign strb.capture = capHit;
  assign strb.latchIn = equEvent;
  assign strb.condIn  = condIn;

  AST_CAP_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (strb.condIn != $past(strb.condIn))); // R3

  AST_LOW_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b10) |-> !inLevel); // R2

endmodule

// File: rtl/cap_chan_dp.sv
module cap_chan_dp
  import cap_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] count,
  input  capStrobes_t      strb,
  input  logic             clrFlag,
  input  logic             clrOvf,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag,
  output logic             ovfFlag,
  output logic             inLatched
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValue  <= '0;
      capFlag   <= 1'b0;
      ovfFlag   <= 1'b0;
      inLatched <= 1'b0;
    end else begin
      if (strb.capture) begin
        capValue <= count;
        capFlag  <= 1'b1;
      end else if (clrFlag) begin
        capFlag  <= 1'b0;
      end
      if (strb.capture && capFlag) ovfFlag <= 1'b1;
      else if (clrOvf)             ovfFlag <= 1'b0;
      if (strb.latchIn) inLatched <= strb.condIn;
    end
  end

  AST_CAP_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (capValue == $past(count))); // R3

  AST_CAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> capFlag); // R5

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlag && !strb.capture) |=> !capFlag); // R6

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && capFlag) |=> ovfFlag); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrOvf) |=> ovfFlag); // R7

  AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(capValue)); // R10

endmodule

// File: rtl/capture_channel.sv
module capture_channel
  import cap_chan_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] count,
  input  logic             srcA,
  input  logic             srcB,
  input  logic [1:0]       srcSel,
  input  logic             syncEn,
  input  logic [1:0]       edgeMode,
  input  logic             equEvent,
  input  logic             irqEn,
  input  logic             clrFlag,
  input  logic             clrOvf,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag,
  output logic             ovfFlag,
  output logic             irq,
  output logic             inLevel,
  output logic             inLatched
);

  capStrobes_t strb;

  cap_chan_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srcA     (srcA),
    .srcB     (srcB),
    .srcSel   (srcSel),
    .syncEn   (syncEn),
    .edgeMode (edgeMode),
    .equEvent (equEvent),
    .inLevel  (inLevel),
    .strb     (strb)
  );

  cap_chan_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .count     (count),
    .strb      (strb),
    .clrFlag   (clrFlag),
    .clrOvf    (clrOvf),
    .capValue  (capValue),
    .capFlag   (capFlag),
    .ovfFlag   (ovfFlag),
    .inLatched (inLatched)
  );

  assign irq = capFlag & irqEn;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqEn && capFlag)); // R5

endmodule

// File: tb/capture_channel_bench.sv
`timescale 1ns/1ps
module capture_channel_bench;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] count = '0;
  logic             srcA = 1'b0, srcB = 1'b0;
  logic [1:0]       srcSel = 2'b00;
  logic             syncEn = 1'b0;
  logic [1:0]       edgeMode = 2'b00;
  logic             equEvent = 1'b0, irqEn = 1'b0, clrFlag = 1'b0, clrOvf = 1'b0;
  logic [CNT_W-1:0] capValue;
  logic             capFlag, ovfFlag, irq, inLevel, inLatched;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  logic             m1 = 0, m2 = 0, mPrev = 0;
  logic [CNT_W-1:0] mCap = '0;
  logic             mFlag = 0, mOvf = 0, mLat = 0;

  always #10 clk = ~clk;  // 50 MHz

  capture_channel #(.CNT_W(CNT_W), .SYNC_DEPTH(2)) u_capture_channel (
    .clk(clk), .rstN(rstN), .count(count), .srcA(srcA), .srcB(srcB),
    .srcSel(srcSel), .syncEn(syncEn), .edgeMode(edgeMode), .equEvent(equEvent),
    .irqEn(irqEn), .clrFlag(clrFlag), .clrOvf(clrOvf), .capValue(capValue),
    .capFlag(capFlag), .ovfFlag(ovfFlag), .irq(irq), .inLevel(inLevel),
    .inLatched(inLatched)
  );

  function automatic logic pickSrc(logic [1:0] s, logic a, logic b);
    case (s)
      2'b00:   return a;
      2'b01:   return b;
      2'b10:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic isCapture(logic [1:0] mode, logic cur, logic prv);
    logic r, f;
    r = cur & ~prv;
    f = ~cur & prv;
    case (mode)
      2'b01:   return r;
      2'b10:   return f;
      2'b11:   return r | f;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    check("R3 capValue", 32'(capValue), 32'(mCap));
    check("R5 capFlag", 32'(capFlag), 32'(mFlag));
    check("R7 ovfFlag", 32'(ovfFlag), 32'(mOvf));
    check("R5 irq", 32'(irq), 32'(mFlag & irqEn));
    check("R2 inLevel", 32'(inLevel), 32'(pickSrc(srcSel, srcA, srcB)));
    check("R8 inLatched", 32'(inLatched), 32'(mLat));
  endtask

  // one clock: inputs already driven at the falling edge
  task automatic tick();
    logic cond, cap;
    @(posedge clk);
    cond = syncEn ? m2 : m1;
    cap  = isCapture(edgeMode, cond, mPrev);
    if (cap && mFlag) mOvf = 1'b1;
    else if (clrOvf)  mOvf = 1'b0;
    if (cap) begin
      mCap  = count;
      mFlag = 1'b1;
    end else if (clrFlag) begin
      mFlag = 1'b0;
    end
    if (equEvent) mLat = cond;
    m2    = m1;
    m1    = pickSrc(srcSel, srcA, srcB);
    mPrev = cond;
    @(negedge clk);
    count = count + CNT_W'(1 + ($urandom % 3));
    checkAll();
  endtask

  task automatic clearStrobes();
    clrFlag  = 1'b0;
    clrOvf   = 1'b0;
    equEvent = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [CNT_W-1:0] expCount;
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 capValue", 32'(capValue), 0);
    check("R1 capFlag", 32'(capFlag), 0);
    check("R1 ovfFlag", 32'(ovfFlag), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 inLatched", 32'(inLatched), 0);
    rstN = 1'b1;

    // R4 latency, single stage
    edgeMode = 2'b01; srcSel = 2'b00; syncEn = 1'b0; irqEn = 1'b1;
    repeat (3) tick();
    srcA = 1'b1;
    tick();
    check("R4 no capture after one edge", 32'(capFlag), 0);
    expCount = count;
    tick();
    check("R4 captured at second edge", 32'(capFlag), 1);
    check("R4 captured count", 32'(capValue), 32'(expCount));
    check("R5 irq raised", 32'(irq), 1);

    // R4 latency, synchronized
    srcA = 1'b0; syncEn = 1'b1;
    repeat (4) tick();
    clrFlag = 1'b1; clrOvf = 1'b1; tick(); clearStrobes();
    check("R6 flag cleared", 32'(capFlag), 0);
    srcA = 1'b1;
    tick(); tick();
    check("R4 sync no capture after two edges", 32'(capFlag), 0);
    expCount = count;
    tick();
    check("R4 sync captured at third edge", 32'(capFlag), 1);
    check("R4 sync captured count", 32'(capValue), 32'(expCount));

    // R9 software trigger via constant sources
    syncEn = 1'b0; edgeMode = 2'b11; srcSel = 2'b10;
    repeat (3) tick();
    clrFlag = 1'b1; clrOvf = 1'b1; tick(); clearStrobes();
    srcSel = 2'b11;
    tick(); tick();
    check("R9 low to high captures", 32'(capFlag), 1);
    check("R7 no overflow yet", 32'(ovfFlag), 0);
    srcSel = 2'b10;
    tick(); tick();
    check("R7 overflow on unread capture", 32'(ovfFlag), 1);
    clrFlag = 1'b1; tick(); clearStrobes();
    check("R7 overflow sticky past flag clear", 32'(ovfFlag), 1);
    clrOvf = 1'b1; tick(); clearStrobes();
    check("R7 overflow cleared", 32'(ovfFlag), 0);

    // R6 capture and clear in the same cycle
    srcSel = 2'b11; tick();
    clrFlag = 1'b1; tick(); clearStrobes();
    check("R6 capture beats clear", 32'(capFlag), 1);

    // R10 mode off
    clrFlag = 1'b1; tick(); clearStrobes();
    edgeMode = 2'b00; expCount = capValue;
    for (int i = 0; i < 6; i++) begin
      srcSel = (i % 2 == 0) ? 2'b10 : 2'b11;
      tick();
    end
    check("R10 no flag when off", 32'(capFlag), 0);
    check("R10 value held when off", 32'(capValue), 32'(expCount));

    // R8 latch on compare-equal
    srcSel = 2'b11; repeat (3) tick();
    equEvent = 1'b1; tick(); clearStrobes();
    check("R8 latched high", 32'(inLatched), 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 == 0)  srcA = ~srcA;
      if ($urandom % 5 == 0)  srcB = ~srcB;
      if ($urandom % 16 == 0) srcSel = 2'($urandom);
      if ($urandom % 40 == 0) syncEn = ~syncEn;
      if ($urandom % 50 == 0) edgeMode = 2'($urandom);
      if ($urandom % 30 == 0) irqEn = ~irqEn;
      equEvent = ($urandom % 8 == 0);
      clrFlag  = ($urandom % 6 == 0);
      clrOvf   = ($urandom % 10 == 0);
      tick();
      clearStrobes();
    end
    finish();
  end

endmodule